// File: doc/BRIEF.md
# Transient Network Simulation Engine

This block evaluates a small gate network in the domain of transients, where a transient is a word of alternating 0s and 1s. Each transient stands for a signal waveform, and its length gives the number of worst-case signal changes plus one. The network holds up to `N_VAR` state variables. Each variable has its own gate, which can be a buffer, an inverter, a two-input AND or a two-input OR. Each gate operand can come from any external input or from any state variable. The engine steps the network toward a fixed point, one step per clock. Each step counts the worst-case changes and exposes hazards. The initial state does not have to be stable.

Software sets up the gates, the binary input vector, the binary initial state and a step limit, then pulses `start`. The engine copies these settings and raises `busy`. From then on it updates every variable at once on each clock. It stops when a step leaves the state unchanged, when it reaches the step limit, or when a transient would become longer than the length field can hold. When it stops it drops `busy`, pulses `done` for one cycle, and holds the final transients and the step count until the next start. `no_fixpoint` reports a run that ended without reaching a fixed point.

Top module: `tnet_sim_engine`

## Requirements
- R1: After reset `busy`, `done` and `no_fixpoint` are 0 and `step_count` is 0. Every variable reads as first symbol 0 with length 1.
- R2: A `start` pulse while idle copies `in_vec`, `init_vec`, the gate settings and `step_limit`. In the next cycle `busy` is 1, `step_count` is 0, and variable k reads as the one-symbol transient `init_vec[k]`. Changes on these ports during a run have no effect on the run.
- R3: On every clock while busy, all variables update together from the previous state, and `step_count` rises by one. The new value of a variable is its copied initial bit joined in front of its excitation, with any repeated symbol removed. The excitation is evaluated on the previous state.
- R4: The gate code in `gate_op[2k+1:2k]` sets the gate: 0 buffers operand A, 1 inverts A, 2 gives AND(A,B), 3 gives OR(A,B). The two-input gates give the longest alternating result that any order of single operand symbol changes can produce. A select code s below `N_IN` picks the constant input bit s. A code `N_IN+j` picks variable j. Any higher code gives constant 0.
- R5: Bit k of `tr_first` is the first symbol of variable k. `tr_len[k*LW +: LW]` is its length. The symbols alternate from the first one.
- R6: While a run is in progress, each variable's new value has the old value as a prefix. The first symbol never changes and the length never shrinks.
- R7: When a step gives a state equal to the previous one, `busy` falls, `done` is 1 for exactly one cycle and `no_fixpoint` is 0. `step_count` then counts every step, including the final unchanged one.
- R8: If the step count reaches the limit without a fixed point, the run stops with `no_fixpoint` set to 1. A `step_limit` of 0 selects the default limit `DEF_LIMIT` (32).
- R9: A fixed point reached on the same step that reaches the limit counts as convergence, so `no_fixpoint` is 0.
- R10: A length that would go above 2^LW−1 is clamped to 2^LW−1. The run then stops on that step with `no_fixpoint` set to 1.
- R11: A `start` pulse while busy is ignored.
- R12: After `done`, the transients and `step_count` hold their values until the next start.
- R13: In a feedback-free network whose deepest variable is at level L, the run reaches a fixed point within L+1 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| in_vec | input | N_IN | Binary external inputs, held constant during the run |
| init_vec | input | N_VAR | Binary initial state |
| gate_op | input | 2*N_VAR | Gate code per variable |
| gate_sel_a | input | SW*N_VAR | Operand A source per variable |
| gate_sel_b | input | SW*N_VAR | Operand B source per variable |
| step_limit | input | CW | Step limit, 0 selects the default |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| no_fixpoint | output | 1 | The run ended by the limit or by length overflow |
| step_count | output | CW | Steps executed in the current or last run |
| tr_first | output | N_VAR | First symbol per variable |
| tr_len | output | LW*N_VAR | Transient length per variable |

## Verification
Convergence and the step limit can fall on the same clock. The bench first measures the number of steps a feedback-free network needs. It then reruns the same network with the limit set to exactly that count, and again with one step less. The first rerun must end with `no_fixpoint` low and the second with it high. The reference model applies the same rule, and every cycle of each run is compared with it. A start pulse sent into the middle of an oscillating run covers the other collision: a start request that arrives while a step is advancing.

// File: rtl/tnet_pkg.sv
package tnet_pkg;

   typedef enum logic [1:0] {
      GATE_BUF = 2'd0,
      GATE_INV = 2'd1,
      GATE_AND = 2'd2,
      GATE_OR  = 2'd3
   } gate_kind_e;

endpackage

// File: rtl/tnet_src_mux.sv
module tnet_src_mux #(
   parameter int N_IN  = 4,
   parameter int N_VAR = 8,
   parameter int LW    = 8,
   parameter int SW    = 4
) (
   input  logic [SW-1:0]       sel,
   input  logic [N_IN-1:0]     in_bits,
   input  logic [N_VAR-1:0]    var_first,
   input  logic [N_VAR*LW-1:0] var_len,
   output logic                o_first,
   output logic [LW-1:0]       o_len
);

   // inputs are constant one-symbol transients; out-of-range codes give 0
   always_comb begin
      o_first = 1'b0;
      o_len   = LW'(1);
      for (int s = 0; s < N_IN; s++) begin
         if (sel == SW'(s)) begin
            o_first = in_bits[s];
         end
      end
      for (int j = 0; j < N_VAR; j++) begin
         if (sel == SW'(N_IN + j)) begin
            o_first = var_first[j];
            o_len   = var_len[j*LW +: LW];
         end
      end
   end

endmodule

// File: rtl/tnet_gate_eval.sv
module tnet_gate_eval
   import tnet_pkg::*;
#(
   parameter int LW = 8
) (
   input  gate_kind_e    kind,
   input  logic          a_first,
   input  logic [LW-1:0] a_len,
   input  logic          b_first,
   input  logic [LW-1:0] b_len,
   input  logic          init_bit,
   output logic          nx_first,
   output logic [LW-1:0] nx_len,
   output logic          nx_sat
);

   localparam int EW      = LW + 2;
   localparam int LEN_MAX = (1 << LW) - 1;

   // count of symbol 'want' in an alternating word
   function automatic logic [EW-1:0] sym_count(input logic f, input logic [EW-1:0] l,
                                               input logic want);
      return (f == want) ? ((l + EW'(1)) >> 1) : (l >> 1);
   endfunction

   // length of an alternating word from the count of one symbol and whether
   // its first / last position holds that symbol
   function automatic logic [EW-1:0] shape(input logic hit_first, input logic hit_last,
                                           input logic [EW-1:0] c);
      if (hit_first && hit_last)      return (c << 1) - EW'(1);
      else if (hit_first ^ hit_last)  return c << 1;
      else                            return (c << 1) + EW'(1);
   endfunction

   logic [EW-1:0] la, lb, cnt, ex_len, full_len;
   logic          a_last, b_last, a_zero, b_zero, a_one, b_one;
   logic          ex_first, ex_last;

   always_comb begin
      la     = EW'(a_len);
      lb     = EW'(b_len);
      a_last = a_first ^ ~a_len[0];
      b_last = b_first ^ ~b_len[0];
      a_zero = (a_len == LW'(1)) && !a_first;
      b_zero = (b_len == LW'(1)) && !b_first;
      a_one  = (a_len == LW'(1)) &&  a_first;
      b_one  = (b_len == LW'(1)) &&  b_first;
      cnt      = '0;
      ex_last  = 1'b0;
      ex_first = a_first;
      ex_len   = la;
      case (kind)
         GATE_BUF: begin
            ex_first = a_first;
            ex_len   = la;
         end
         GATE_INV: begin
            ex_first = ~a_first;
            ex_len   = la;
         end
         GATE_AND: begin
            if (a_zero || b_zero) begin
               ex_first = 1'b0;
               ex_len   = EW'(1);
            end else begin
               ex_first = a_first & b_first;
               ex_last  = a_last & b_last;
               cnt      = sym_count(a_first, la, 1'b1) + sym_count(b_first, lb, 1'b1) - EW'(1);
               ex_len   = shape(ex_first, ex_last, cnt);
            end
         end
         default: begin
            if (a_one || b_one) begin
               ex_first = 1'b1;
               ex_len   = EW'(1);
            end else begin
               ex_first = a_first | b_first;
               ex_last  = a_last | b_last;
               cnt      = sym_count(a_first, la, 1'b0) + sym_count(b_first, lb, 1'b0) - EW'(1);
               ex_len   = shape(~ex_first, ~ex_last, cnt);
            end
         end
      endcase
      // join the initial bit in front, dropping a repeat
      nx_first = init_bit;
      full_len = (init_bit == ex_first) ? ex_len : ex_len + EW'(1);
      if (full_len > EW'(LEN_MAX)) begin
         nx_len = LW'(LEN_MAX);
         nx_sat = 1'b1;
      end else begin
         nx_len = full_len[LW-1:0];
         nx_sat = 1'b0;
      end
   end

endmodule

// File: rtl/tnet_step_ctrl.sv
module tnet_step_ctrl #(
   parameter int CW        = 8,
   parameter int DEF_LIMIT = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] limit_cfg,
   input  logic          all_same,
   input  logic          any_sat,
   output logic          load,
   output logic          advance,
   output logic          busy,
   output logic          done,
   output logic          no_fix,
   output logic [CW-1:0] count
);

   logic [CW-1:0] lim_q, cnt_nx;
   logic          stop_now;

   assign load     = start & ~busy;
   assign advance  = busy;
   assign cnt_nx   = count + CW'(1);
   assign stop_now = all_same | any_sat | (cnt_nx >= lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         no_fix <= 1'b0;
         count  <= '0;
         lim_q  <= CW'(DEF_LIMIT);
      end else if (load) begin
         busy   <= 1'b1;
         done   <= 1'b0;
         no_fix <= 1'b0;
         count  <= '0;
         lim_q  <= (limit_cfg == '0) ? CW'(DEF_LIMIT) : limit_cfg;
      end else if (busy) begin
         count <= cnt_nx;
         if (stop_now) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            no_fix <= any_sat | ~all_same;
         end
      end else begin
         done <= 1'b0;
      end
   end

endmodule

// File: rtl/tnet_sim_engine.sv
module tnet_sim_engine
   import tnet_pkg::*;
#(
   parameter int N_IN      = 4,
   parameter int N_VAR     = 8,
   parameter int LW        = 8,
   parameter int CW        = 8,
   parameter int DEF_LIMIT = 32,
   parameter int SW        = $clog2(N_IN + N_VAR + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [N_IN-1:0]     in_vec,
   input  logic [N_VAR-1:0]    init_vec,
   input  logic [2*N_VAR-1:0]  gate_op,
   input  logic [SW*N_VAR-1:0] gate_sel_a,
   input  logic [SW*N_VAR-1:0] gate_sel_b,
   input  logic [CW-1:0]       step_limit,
   output logic                busy,
   output logic                done,
   output logic                no_fixpoint,
   output logic [CW-1:0]       step_count,
   output logic [N_VAR-1:0]    tr_first,
   output logic [LW*N_VAR-1:0] tr_len
);

   if (N_IN < 1 || N_VAR < 1 || N_VAR > 32) begin : g_bad_size
      $error("tnet_sim_engine: N_IN/N_VAR out of range");
   end
   if (LW < 2) begin : g_bad_lw
      $error("tnet_sim_engine: LW must be at least 2");
   end
   if (DEF_LIMIT < 1 || DEF_LIMIT >= (1 << CW)) begin : g_bad_limit
      $error("tnet_sim_engine: DEF_LIMIT does not fit CW");
   end
   if ((1 << SW) < N_IN + N_VAR) begin : g_bad_sw
      $error("tnet_sim_engine: SW too narrow for the source count");
   end

   logic [N_IN-1:0]     in_q;
   logic [N_VAR-1:0]    init_q;
   logic [2*N_VAR-1:0]  op_q;
   logic [SW*N_VAR-1:0] sa_q, sb_q;
   logic [N_VAR-1:0]    st_first, nx_first, nx_sat;
   logic [LW*N_VAR-1:0] st_len, nx_len;
   logic                load, advance, all_same, any_sat;

   assign all_same = (nx_first == st_first) && (nx_len == st_len);
   assign any_sat  = |nx_sat;

   tnet_step_ctrl #(.CW(CW), .DEF_LIMIT(DEF_LIMIT)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .limit_cfg (step_limit),
      .all_same  (all_same),
      .any_sat   (any_sat),
      .load      (load),
      .advance   (advance),
      .busy      (busy),
      .done      (done),
      .no_fix    (no_fixpoint),
      .count     (step_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q   <= '0;
         init_q <= '0;
         op_q   <= '0;
         sa_q   <= '0;
         sb_q   <= '0;
      end else if (load) begin
         in_q   <= in_vec;
         init_q <= init_vec;
         op_q   <= gate_op;
         sa_q   <= gate_sel_a;
         sb_q   <= gate_sel_b;
      end
   end

   for (genvar k = 0; k < N_VAR; k++) begin : g_var
      logic          a_first, b_first;
      logic [LW-1:0] a_len, b_len;

      tnet_src_mux #(.N_IN(N_IN), .N_VAR(N_VAR), .LW(LW), .SW(SW)) u_mux_a (
         .sel       (sa_q[k*SW +: SW]),
         .in_bits   (in_q),
         .var_first (st_first),
         .var_len   (st_len),
         .o_first   (a_first),
         .o_len     (a_len)
      );

      tnet_src_mux #(.N_IN(N_IN), .N_VAR(N_VAR), .LW(LW), .SW(SW)) u_mux_b (
         .sel       (sb_q[k*SW +: SW]),
         .in_bits   (in_q),
         .var_first (st_first),
         .var_len   (st_len),
         .o_first   (b_first),
         .o_len     (b_len)
      );

      tnet_gate_eval #(.LW(LW)) u_eval (
         .kind     (gate_kind_e'(op_q[2*k +: 2])),
         .a_first  (a_first),
         .a_len    (a_len),
         .b_first  (b_first),
         .b_len    (b_len),
         .init_bit (init_q[k]),
         .nx_first (nx_first[k]),
         .nx_len   (nx_len[k*LW +: LW]),
         .nx_sat   (nx_sat[k])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_first[k]          <= 1'b0;
            st_len[k*LW +: LW]   <= LW'(1);
         end else if (load) begin
            st_first[k]          <= init_vec[k];
            st_len[k*LW +: LW]   <= LW'(1);
         end else if (advance) begin
            st_first[k]          <= nx_first[k];
            st_len[k*LW +: LW]   <= nx_len[k*LW +: LW];
         end
      end
   end

   assign tr_first = st_first;
   assign tr_len   = st_len;

endmodule

// File: rtl/tnet_sim_engine_chk.sv
module tnet_sim_engine_chk #(
   parameter int N_VAR = 8,
   parameter int LW    = 8,
   parameter int CW    = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                busy,
   input logic                done,
   input logic                no_fixpoint,
   input logic [CW-1:0]       step_count,
   input logic [N_VAR-1:0]    tr_first,
   input logic [LW*N_VAR-1:0] tr_len
);

   p_step_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> step_count == CW'($past(step_count) + CW'(1)));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_flag_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(no_fixpoint) |-> done);

   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> step_count != '0);

   p_hold_after_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy) && !$rose(busy)) |-> ($stable(tr_first) && $stable(tr_len)));

   for (genvar k = 0; k < N_VAR; k++) begin : g_var
      p_prefix_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $past(busy) |-> tr_first[k] == $past(tr_first[k]));

      p_prefix_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $past(busy) |-> tr_len[k*LW +: LW] >= $past(tr_len[k*LW +: LW]));

      p_load_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(busy) |-> (tr_len[k*LW +: LW] == LW'(1) && step_count == '0));
   end

endmodule

bind tnet_sim_engine tnet_sim_engine_chk #(.N_VAR(N_VAR), .LW(LW), .CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .done        (done),
   .no_fixpoint (no_fixpoint),
   .step_count  (step_count),
   .tr_first    (tr_first),
   .tr_len      (tr_len)
);

// File: tb/tb_tnet_sim_engine.sv
`timescale 1ns/1ps
module tb_tnet_sim_engine;

   localparam int N_IN  = 4;
   localparam int N_VAR = 8;
   localparam int LW    = 8;
   localparam int CW    = 8;
   localparam int SW    = 4;
   localparam int LMAX  = 255;
   localparam int DEFL  = 32;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic [N_IN-1:0]     in_vec = '0;
   logic [N_VAR-1:0]    init_vec = '0;
   logic [2*N_VAR-1:0]  gate_op = '0;
   logic [SW*N_VAR-1:0] gate_sel_a = '0;
   logic [SW*N_VAR-1:0] gate_sel_b = '0;
   logic [CW-1:0]       step_limit = '0;
   logic                busy, done, no_fixpoint;
   logic [CW-1:0]       step_count;
   logic [N_VAR-1:0]    tr_first;
   logic [LW*N_VAR-1:0] tr_len;

   always #2 clk = ~clk;

   tnet_sim_engine #(.N_IN(N_IN), .N_VAR(N_VAR), .LW(LW), .CW(CW), .DEF_LIMIT(DEFL)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec), .init_vec(init_vec),
      .gate_op(gate_op), .gate_sel_a(gate_sel_a), .gate_sel_b(gate_sel_b),
      .step_limit(step_limit), .busy(busy), .done(done), .no_fixpoint(no_fixpoint),
      .step_count(step_count), .tr_first(tr_first), .tr_len(tr_len)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // configuration seen by the model
   int m_op[N_VAR], m_sa[N_VAR], m_sb[N_VAR], m_init[N_VAR], m_in[N_IN];
   // model state
   int mf[N_VAR], ml[N_VAR];

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int glab(input int op, input int x, input int y);
      return (op == 2) ? (x & y) : (x | y);
   endfunction

   // longest alternation over all single-symbol orderings of the two operands
   function automatic void ext2(input int op, input int fa, input int la, input int fb, input int lb,
                                output int fr, output int lr);
      int best[];
      best = new[la * lb];
      for (int i = 0; i < la; i++) begin
         for (int j = 0; j < lb; j++) begin
            int lab, v;
            lab = glab(op, fa ^ (i & 1), fb ^ (j & 1));
            v = 0;
            if (i > 0) begin
               int c;
               c = best[(i-1)*lb + j] + ((glab(op, fa ^ ((i-1) & 1), fb ^ (j & 1)) != lab) ? 1 : 0);
               if (c > v) v = c;
            end
            if (j > 0) begin
               int c;
               c = best[i*lb + j - 1] + ((glab(op, fa ^ (i & 1), fb ^ ((j-1) & 1)) != lab) ? 1 : 0);
               if (c > v) v = c;
            end
            best[i*lb + j] = v;
         end
      end
      fr = glab(op, fa, fb);
      lr = best[la*lb - 1] + 1;
   endfunction

   function automatic void src(input int sel, output int f, output int l);
      if (sel < N_IN) begin
         f = m_in[sel]; l = 1;
      end else if (sel < N_IN + N_VAR) begin
         f = mf[sel - N_IN]; l = ml[sel - N_IN];
      end else begin
         f = 0; l = 1;
      end
   endfunction

   function automatic void model_step(output bit conv, output bit sat);
      int nf[N_VAR], nl[N_VAR];
      conv = 1; sat = 0;
      for (int k = 0; k < N_VAR; k++) begin
         int fa, la, fb, lb, ef, el;
         src(m_sa[k], fa, la);
         src(m_sb[k], fb, lb);
         if (m_op[k] == 0)      begin ef = fa;     el = la; end
         else if (m_op[k] == 1) begin ef = 1 - fa; el = la; end
         else ext2(m_op[k], fa, la, fb, lb, ef, el);
         nf[k] = m_init[k];
         nl[k] = (m_init[k] == ef) ? el : el + 1;
         if (nl[k] > LMAX) begin nl[k] = LMAX; sat = 1; end
      end
      for (int k = 0; k < N_VAR; k++) begin
         if (nf[k] != mf[k] || nl[k] != ml[k]) conv = 0;
         mf[k] = nf[k]; ml[k] = nl[k];
      end
   endfunction

   task automatic cmp_state(input string req);
      for (int k = 0; k < N_VAR; k++) begin
         check(int'(tr_first[k]) == mf[k], req, $sformatf("first of var %0d", k), int'(tr_first[k]), mf[k]);
         check(int'(tr_len[k*LW +: LW]) == ml[k], req, $sformatf("length of var %0d", k),
               int'(tr_len[k*LW +: LW]), ml[k]);
      end
   endtask

   task automatic clear_cfg();
      for (int k = 0; k < N_VAR; k++) begin
         m_op[k] = 0; m_sa[k] = N_IN + k; m_sb[k] = N_IN + k; m_init[k] = 0;
      end
      for (int i = 0; i < N_IN; i++) m_in[i] = 0;
   endtask

   task automatic run_case(input int lim, input bit poke, output int steps, output bit flag);
      int cnt, eff;
      bit conv, sat, stop;
      for (int k = 0; k < N_VAR; k++) begin
         gate_op[2*k +: 2]      = 2'(m_op[k]);
         gate_sel_a[k*SW +: SW] = SW'(m_sa[k]);
         gate_sel_b[k*SW +: SW] = SW'(m_sb[k]);
         init_vec[k]            = m_init[k][0];
      end
      for (int i = 0; i < N_IN; i++) in_vec[i] = m_in[i][0];
      step_limit = CW'(lim);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      // R2: port changes during the run must not matter
      in_vec = ~in_vec; gate_op = ~gate_op; init_vec = ~init_vec; step_limit = CW'(1);
      for (int k = 0; k < N_VAR; k++) begin mf[k] = m_init[k]; ml[k] = 1; end
      eff = (lim == 0) ? DEFL : lim;
      cnt = 0; flag = 0;
      check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
      check(int'(step_count) == 0, "R2", "step count after start", int'(step_count), 0);
      cmp_state("R2");
      forever begin
         model_step(conv, sat);
         cnt++;
         stop = conv || sat || (cnt >= eff);
         flag = sat || !conv;
         if (poke && cnt == 3 && !stop) start = 1'b1;  // R11: start while busy
         @(negedge clk);
         start = 1'b0;
         cmp_state("R3 R4 R5");
         check(int'(step_count) == cnt, "R3", "step count", int'(step_count), cnt);
         check(busy == !stop, "R7", "busy", int'(busy), int'(!stop));
         check(done == stop, "R7", "done", int'(done), int'(stop));
         if (stop) begin
            check(no_fixpoint == flag, "R8", "no_fixpoint", int'(no_fixpoint), int'(flag));
            break;
         end
      end
      @(negedge clk);
      check(done == 1'b0, "R7", "done one cycle", int'(done), 0);
      check(int'(step_count) == cnt, "R12", "count held", int'(step_count), cnt);
      cmp_state("R12");
      steps = cnt;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int steps, c;
      bit flag;
      int unsigned seed;
      clear_cfg();
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 0 && done == 0 && no_fixpoint == 0, "R1", "idle flags", int'({busy, done, no_fixpoint}), 0);
      check(int'(step_count) == 0, "R1", "reset count", int'(step_count), 0);
      for (int k = 0; k < N_VAR; k++) begin mf[k] = 0; ml[k] = 1; end
      cmp_state("R1");
      rst_n = 1'b1;
      @(negedge clk);

      // stable start: fixed point after one step
      clear_cfg();
      m_in[0] = 1; m_op[0] = 0; m_sa[0] = 0; m_init[0] = 1;
      run_case(0, 0, steps, flag);
      check(steps == 1, "R7", "stable network steps", steps, 1);
      check(flag == 0, "R7", "stable network flag", int'(flag), 0);

      // feedback-free network with an unstable start, depth 4
      clear_cfg();
      m_in[0] = 0; m_in[1] = 0;
      m_op[0] = 0; m_sa[0] = 0;                    m_init[0] = 1;
      m_op[1] = 1; m_sa[1] = 1;                    m_init[1] = 1;
      m_op[2] = 2; m_sa[2] = N_IN+0; m_sb[2] = N_IN+1; m_init[2] = 1;
      m_op[3] = 3; m_sa[3] = N_IN+2; m_sb[3] = N_IN+0; m_init[3] = 0;
      m_op[4] = 2; m_sa[4] = N_IN+3; m_sb[4] = N_IN+2; m_init[4] = 1;
      m_op[5] = 0; m_sa[5] = 15;                   m_init[5] = 1;
      run_case(0, 0, steps, flag);
      c = steps;
      check(steps <= 5, "R13", "feedback-free step bound", steps, 5);
      check(flag == 0, "R13", "feedback-free converges", int'(flag), 0);

      // limit equal to the convergence step, then one below
      run_case(c, 0, steps, flag);
      check(flag == 0, "R9", "fixed point on limit step", int'(flag), 0);
      if (c >= 2) begin
         run_case(c - 1, 0, steps, flag);
         check(flag == 1, "R8", "limit one short", int'(flag), 1);
      end

      // two-variable ring that grows each step, with a start poke mid-run
      clear_cfg();
      m_op[0] = 1; m_sa[0] = N_IN+1;
      m_op[1] = 0; m_sa[1] = N_IN+0;
      run_case(10, 1, steps, flag);
      check(steps == 10, "R8", "ring stops at limit", steps, 10);
      check(flag == 1, "R11", "ring flag with ignored start", int'(flag), 1);

      // doubling loop overflows the length field, default limit
      clear_cfg();
      m_op[0] = 3; m_sa[0] = N_IN+1; m_sb[0] = N_IN+1;
      m_op[1] = 1; m_sa[1] = N_IN+0;
      run_case(0, 0, steps, flag);
      check(flag == 1, "R10", "overflow flag", int'(flag), 1);
      check(steps < DEFL, "R10", "overflow ends early", steps, DEFL);

      // assorted networks
      seed = 32'h1234_5678;
      for (int r = 0; r < 6; r++) begin
         clear_cfg();
         for (int i = 0; i < N_IN; i++) begin
            seed = seed * 1103515245 + 12345; m_in[i] = int'((seed >> 16) & 1);
         end
         for (int k = 0; k < N_VAR; k++) begin
            seed = seed * 1103515245 + 12345; m_op[k] = int'((seed >> 16) & 3);
            seed = seed * 1103515245 + 12345; m_sa[k] = int'((seed >> 16) % (N_IN + N_VAR));
            seed = seed * 1103515245 + 12345; m_sb[k] = int'((seed >> 16) % (N_IN + N_VAR));
            seed = seed * 1103515245 + 12345; m_init[k] = int'((seed >> 16) & 1);
         end
         run_case(12, 0, steps, flag);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule